// File: doc/BRIEF.md
# Utility Bus Transceiver Controller

This block drives the two control pins of an 8-bit bidirectional buffer that joins a system data bus to a slower peripheral data bus. One output chooses the buffer direction: high means data flows from the peripheral side toward the system side. The other is an active-low enable that opens the buffer. Both outputs follow the four active-low command strobes (I/O read, I/O write, memory read, memory write) and the DMA acknowledges. All of these inputs are asynchronous to the block clock and are synchronized inside it.

When a command strobe falls, the block decodes the address. It then checks per-device enable bits, the disk-change level latched at reset, and the IDE-resident flag, and fixes the buffer state for the whole command. Direction points toward the system bus on every I/O read, even when no device answers. Memory reads turn the buffer around only for the BIOS window. A set of floppy, IDE and DMA special cases keeps the enable closed. During DMA, the outputs follow the acknowledges instead of the strobes.

Top module: `utb_xcvr_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `xcvr_dir` is 0 and `xcvr_oe_n` is 1.
- R2: Every I/O read drives `xcvr_dir` to 1, whatever the address and whatever the enable bits.
- R3: A memory read drives `xcvr_dir` to 1 only when the address lies in 0E0000h–0FFFFFh and `cs_en[4]` is set. Otherwise `xcvr_dir` stays 0.
- R4: Both outputs change on the third rising clock edge after a strobe or acknowledge changes level. They hold their old value on the second edge.
- R5: Write strobes never raise `xcvr_dir`. When no strobe and no acknowledge has been active for three cycles, `xcvr_dir` is 0.
- R6: `xcvr_oe_n` goes low on any of the four strobes when an enabled device is decoded. The enable bits are: `cs_en[0]` for floppy primary (I/O 3F0h–3F7h), `cs_en[1]` for floppy secondary (I/O 370h–377h), `cs_en[2]` for the keyboard controller (I/O 60h, 64h), `cs_en[3]` for the RTC (I/O 70h, 71h) and `cs_en[4]` for BIOS (memory 0E0000h–0FFFFFh). I/O decode requires `addr[23:16]` = 0. When nothing is active for three cycles, `xcvr_oe_n` is 1.
- R7: An access to a device whose `cs_en` bit is 0, or to an address that hits no device, leaves `xcvr_oe_n` at 1.
- R8: If `dskchg` was low on the last reset cycle, floppy I/O accesses leave `xcvr_oe_n` at 1. Other devices are not affected.
- R9: An I/O read of 3F7h or 377h while `ide_en` is 0 leaves `xcvr_oe_n` at 1. An I/O write to the same port, or the read with `ide_en` = 1, opens the buffer.
- R10: While an acknowledge of a channel in the utility DMA mask (default: channel 2 only) is low and `dma_from_util` was 1 at its falling edge, `xcvr_dir` is 1. Other channels never raise it.
- R11: While `dack_n[2]` is low, `xcvr_oe_n` is 0, unless `dor_ign_dack2` was 1 at the acknowledge's falling edge.
- R12: Address and configuration are captured when the strobe falls. Changing them while the strobe stays low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ior_n | input | 1 | I/O read strobe, active low, asynchronous |
| iow_n | input | 1 | I/O write strobe, active low, asynchronous |
| memr_n | input | 1 | Memory read strobe, active low, asynchronous |
| memw_n | input | 1 | Memory write strobe, active low, asynchronous |
| dack_n | input | NUM_DMA | DMA acknowledges, active low, asynchronous |
| dma_from_util | input | 1 | Active DMA transfer reads from the peripheral bus |
| addr | input | 24 | Address, low 16 bits used for I/O |
| cs_en | input | 5 | Per-device decode enables |
| dor_ign_dack2 | input | 1 | Floppy output register ignores the channel-2 acknowledge |
| ide_en | input | 1 | IDE resident on the peripheral bus |
| dskchg | input | 1 | Disk-change level, latched during reset |
| xcvr_dir | output | 1 | Buffer direction, 1 = toward system bus |
| xcvr_oe_n | output | 1 | Buffer enable, active low |

## Verification
The bound checker watches the cycle-level rules on every cycle. It checks the reset values, that the outputs are never unknown, that an I/O read held low on its own drives the direction high within three cycles, and that both outputs return to idle three cycles after the bus goes quiet. The address-dependent behaviour cannot be seen by a property over the ports alone. This covers the BIOS window, the per-device enables, the disk-change latch, the IDE port exception, the DMA gating and the capture of the address at the strobe edge. Only the bench scenarios show these, and each one samples the outputs on the exact edges where they must change and where they must not yet.

// File: rtl/utb_pkg.sv
package utb_pkg;

    localparam int ADDR_W  = 24;
    localparam int IO_W    = 16;
    localparam int NUM_CMD = 4;
    localparam int NUM_DEV = 5;

    typedef enum logic [1:0] {
        CMD_IOR  = 2'd0,
        CMD_IOW  = 2'd1,
        CMD_MEMR = 2'd2,
        CMD_MEMW = 2'd3
    } cmd_e;

    // one-hot device positions, shared with the enable vector
    localparam int DEV_FDC_PRI = 0;
    localparam int DEV_FDC_SEC = 1;
    localparam int DEV_KBC     = 2;
    localparam int DEV_RTC     = 3;
    localparam int DEV_BIOS    = 4;

    localparam logic [IO_W-1:0]   FDC_PRI_BASE = 16'h03F0;
    localparam logic [IO_W-1:0]   FDC_SEC_BASE = 16'h0370;
    localparam logic [IO_W-1:0]   KBC_DATA     = 16'h0060;
    localparam logic [IO_W-1:0]   KBC_CTRL     = 16'h0064;
    localparam logic [IO_W-1:0]   RTC_INDEX    = 16'h0070;
    localparam logic [IO_W-1:0]   RTC_DATA     = 16'h0071;
    localparam logic [ADDR_W-1:0] BIOS_BASE    = 24'h0E0000;
    localparam int                BIOS_LSB     = 17;
    localparam logic [2:0]        IDE_PORT_LO  = 3'h7;

    typedef struct packed {
        logic dir;
        logic oe;
    } xcvr_ctl_t;

    localparam xcvr_ctl_t CTL_IDLE = '{dir: 1'b0, oe: 1'b0};

    function automatic logic cmd_is_io(input cmd_e c);
        return (c == CMD_IOR) || (c == CMD_IOW);
    endfunction

    function automatic logic fdc_window(input logic [IO_W-1:0] a,
                                        input logic [IO_W-1:0] base);
        return a[IO_W-1:3] == base[IO_W-1:3];
    endfunction

    function automatic logic [NUM_DEV-1:0] decode_io(input logic [ADDR_W-1:0] a);
        logic [NUM_DEV-1:0] hit;
        logic [IO_W-1:0]    p;
        p   = a[IO_W-1:0];
        hit = '0;
        if (a[ADDR_W-1:IO_W] == '0) begin
            hit[DEV_FDC_PRI] = fdc_window(p, FDC_PRI_BASE);
            hit[DEV_FDC_SEC] = fdc_window(p, FDC_SEC_BASE);
            hit[DEV_KBC]     = (p == KBC_DATA) || (p == KBC_CTRL);
            hit[DEV_RTC]     = (p == RTC_INDEX) || (p == RTC_DATA);
        end
        return hit;
    endfunction

    function automatic logic [NUM_DEV-1:0] decode_mem(input logic [ADDR_W-1:0] a);
        logic [NUM_DEV-1:0] hit;
        hit = '0;
        hit[DEV_BIOS] = (a[ADDR_W-1:BIOS_LSB] == BIOS_BASE[ADDR_W-1:BIOS_LSB]);
        return hit;
    endfunction

endpackage

// File: rtl/utb_sync.sv
module utb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_n,
    output logic [W-1:0] fall,
    output logic [W-1:0] rise
);
    // per bit: two metastability flops then one history flop
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q, hist_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                hist_q <= 1'b1;
            end else begin
                meta_q <= async_n[i];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end
        assign fall[i] = hist_q & ~sync_q;
        assign rise[i] = ~hist_q & sync_q;
    end
endmodule

// File: rtl/utb_decode.sv
module utb_decode
    import utb_pkg::*;
(
    input  cmd_e                cmd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_DEV-1:0]  cs_en,
    input  logic                dskchg_low,
    input  logic                ide_en,
    output xcvr_ctl_t           ctl
);
    logic [NUM_DEV-1:0] hit;
    logic               is_io;
    logic               fdc_hit;
    logic               ide_port_blk;
    logic               dsk_blk;
    logic               enabled;

    always_comb begin
        is_io        = cmd_is_io(cmd);
        hit          = is_io ? decode_io(addr) : decode_mem(addr);
        enabled      = |(hit & cs_en);
        fdc_hit      = hit[DEV_FDC_PRI] | hit[DEV_FDC_SEC];
        dsk_blk      = fdc_hit & dskchg_low;
        ide_port_blk = (cmd == CMD_IOR) & fdc_hit
                     & (addr[2:0] == IDE_PORT_LO) & ~ide_en;

        ctl.oe  = enabled & ~dsk_blk & ~ide_port_blk;
        ctl.dir = (cmd == CMD_IOR)
                | ((cmd == CMD_MEMR) & hit[DEV_BIOS] & cs_en[DEV_BIOS]);
    end
endmodule

// File: rtl/utb_cmd_track.sv
module utb_cmd_track
    import utb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CMD-1:0] fall,
    input  logic [NUM_CMD-1:0] rise,
    input  xcvr_ctl_t          dec_ctl,
    output cmd_e               sel_cmd,
    output xcvr_ctl_t          ctl
);
    typedef enum logic {TRK_IDLE, TRK_BUSY} trk_e;

    trk_e      state_q;
    cmd_e      cur_q;
    xcvr_ctl_t ctl_q;

    // lowest index wins when several strobes fall together
    always_comb begin
        sel_cmd = CMD_IOR;
        for (int i = NUM_CMD - 1; i >= 0; i--) begin
            if (fall[i]) sel_cmd = cmd_e'(i[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_IDLE;
            cur_q   <= CMD_IOR;
            ctl_q   <= CTL_IDLE;
        end else begin
            case (state_q)
                TRK_IDLE: if (|fall) begin
                    state_q <= TRK_BUSY;
                    cur_q   <= sel_cmd;
                    ctl_q   <= dec_ctl;
                end
                TRK_BUSY: if (rise[cur_q]) begin
                    state_q <= TRK_IDLE;
                    ctl_q   <= CTL_IDLE;
                end
                default: state_q <= TRK_IDLE;
            endcase
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/utb_dma_track.sv
module utb_dma_track
    import utb_pkg::*;
#(
    parameter int               NUM_DMA   = 4,
    parameter logic [NUM_DMA-1:0] UTIL_MASK = 4'b0100,
    parameter int               FDC_CH    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DMA-1:0] fall,
    input  logic [NUM_DMA-1:0] rise,
    input  logic               dma_from_util,
    input  logic               dor_ign_dack2,
    output xcvr_ctl_t          ctl
);
    logic [NUM_DMA-1:0] dir_q;
    logic [NUM_DMA-1:0] oe_q;

    for (genvar c = 0; c < NUM_DMA; c++) begin : g_ch
        localparam logic IS_FDC = (c == FDC_CH);
        always_ff @(posedge clk) begin
            if (rst) begin
                dir_q[c] <= 1'b0;
                oe_q[c]  <= 1'b0;
            end else if (rise[c]) begin
                dir_q[c] <= 1'b0;
                oe_q[c]  <= 1'b0;
            end else if (fall[c]) begin
                dir_q[c] <= UTIL_MASK[c] & dma_from_util;
                oe_q[c]  <= IS_FDC & ~dor_ign_dack2;
            end
        end
    end

    assign ctl.dir = |dir_q;
    assign ctl.oe  = |oe_q;
endmodule

// File: rtl/utb_xcvr_ctrl.sv
module utb_xcvr_ctrl
    import utb_pkg::*;
#(
    parameter int                 NUM_DMA   = 4,
    parameter logic [NUM_DMA-1:0] UTIL_MASK = 4'b0100,
    parameter int                 FDC_CH    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ior_n,
    input  logic                iow_n,
    input  logic                memr_n,
    input  logic                memw_n,
    input  logic [NUM_DMA-1:0]  dack_n,
    input  logic                dma_from_util,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_DEV-1:0]  cs_en,
    input  logic                dor_ign_dack2,
    input  logic                ide_en,
    input  logic                dskchg,
    output logic                xcvr_dir,
    output logic                xcvr_oe_n
);
    logic [NUM_CMD-1:0] cmd_n;
    logic [NUM_CMD-1:0] cmd_fall, cmd_rise;
    logic [NUM_DMA-1:0] ack_fall, ack_rise;
    logic               dskchg_low_q;
    cmd_e               sel_cmd;
    xcvr_ctl_t          dec_ctl, cmd_ctl, dma_ctl;

    // bit order follows cmd_e
    assign cmd_n = {memw_n, memr_n, iow_n, ior_n};

    // last reset cycle's value is the one kept
    always_ff @(posedge clk) begin
        if (rst) dskchg_low_q <= ~dskchg;
    end

    utb_sync #(.W(NUM_CMD)) u_cmd_sync (
        .clk(clk), .rst(rst), .async_n(cmd_n),
        .fall(cmd_fall), .rise(cmd_rise)
    );

    utb_sync #(.W(NUM_DMA)) u_ack_sync (
        .clk(clk), .rst(rst), .async_n(dack_n),
        .fall(ack_fall), .rise(ack_rise)
    );

    utb_decode u_decode (
        .cmd(sel_cmd), .addr(addr), .cs_en(cs_en),
        .dskchg_low(dskchg_low_q), .ide_en(ide_en), .ctl(dec_ctl)
    );

    utb_cmd_track u_cmd_track (
        .clk(clk), .rst(rst), .fall(cmd_fall), .rise(cmd_rise),
        .dec_ctl(dec_ctl), .sel_cmd(sel_cmd), .ctl(cmd_ctl)
    );

    utb_dma_track #(
        .NUM_DMA(NUM_DMA), .UTIL_MASK(UTIL_MASK), .FDC_CH(FDC_CH)
    ) u_dma_track (
        .clk(clk), .rst(rst), .fall(ack_fall), .rise(ack_rise),
        .dma_from_util(dma_from_util), .dor_ign_dack2(dor_ign_dack2),
        .ctl(dma_ctl)
    );

    assign xcvr_dir  = cmd_ctl.dir | dma_ctl.dir;
    assign xcvr_oe_n = ~(cmd_ctl.oe | dma_ctl.oe);
endmodule

// File: rtl/utb_xcvr_ctrl_chk.sv
module utb_xcvr_ctrl_chk #(
    parameter int NUM_DMA = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ior_n,
    input logic               iow_n,
    input logic               memr_n,
    input logic               memw_n,
    input logic [NUM_DMA-1:0] dack_n,
    input logic               xcvr_dir,
    input logic               xcvr_oe_n
);
    logic       rst_q;
    logic [2:0] quiet_cnt;
    logic [2:0] ior_cnt;
    logic       cmds_high_q;
    logic       all_high;
    logic       ior_solo;

    assign all_high = ior_n & iow_n & memr_n & memw_n & (&dack_n);
    assign ior_solo = ~ior_n & iow_n & memr_n & memw_n;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            quiet_cnt   <= '0;
            ior_cnt     <= '0;
            cmds_high_q <= 1'b0;
        end else begin
            cmds_high_q <= ior_n & iow_n & memr_n & memw_n;
            quiet_cnt   <= !all_high ? 3'd0 : (quiet_cnt == 3'd7 ? quiet_cnt : quiet_cnt + 3'd1);
            if (ior_solo && (ior_cnt != 3'd0 || cmds_high_q))
                ior_cnt <= (ior_cnt == 3'd7) ? ior_cnt : ior_cnt + 3'd1;
            else
                ior_cnt <= '0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst_q |-> (!xcvr_dir && xcvr_oe_n));

    assert_outputs_known_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q == 1'b0 |-> !$isunknown({xcvr_dir, xcvr_oe_n}));

    assert_ior_turns_dir_R2: assert property (@(posedge clk) disable iff (rst)
        ior_cnt >= 3'd3 |-> xcvr_dir);

    assert_quiet_dir_low_R5: assert property (@(posedge clk) disable iff (rst)
        quiet_cnt >= 3'd3 |-> !xcvr_dir);

    assert_quiet_oe_closed_R6: assert property (@(posedge clk) disable iff (rst)
        quiet_cnt >= 3'd3 |-> xcvr_oe_n);
endmodule

bind utb_xcvr_ctrl utb_xcvr_ctrl_chk #(.NUM_DMA(NUM_DMA)) u_chk (
    .clk(clk), .rst(rst), .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n),
    .memw_n(memw_n), .dack_n(dack_n), .xcvr_dir(xcvr_dir), .xcvr_oe_n(xcvr_oe_n)
);

// File: tb/utb_xcvr_ctrl_tb.sv
module utb_xcvr_ctrl_tb;
    localparam int NUM_DMA = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
    logic [NUM_DMA-1:0] dack_n = '1;
    logic               dma_from_util = 1'b0;
    logic [23:0]        addr = '0;
    logic [4:0]         cs_en = 5'b11111;
    logic               dor_ign_dack2 = 1'b0;
    logic               ide_en = 1'b1;
    logic               dskchg = 1'b1;
    logic               xcvr_dir, xcvr_oe_n;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  dir;
        logic  oe_n;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    utb_xcvr_ctrl #(.NUM_DMA(NUM_DMA)) u_dut (
        .clk(clk), .rst(rst), .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n),
        .memw_n(memw_n), .dack_n(dack_n), .dma_from_util(dma_from_util),
        .addr(addr), .cs_en(cs_en), .dor_ign_dack2(dor_ign_dack2),
        .ide_en(ide_en), .dskchg(dskchg), .xcvr_dir(xcvr_dir), .xcvr_oe_n(xcvr_oe_n)
    );

    task automatic compare(input logic ed, input logic eo, input string tag);
        checks++;
        if (xcvr_dir !== ed || xcvr_oe_n !== eo) begin
            fails++;
            $display("FAIL %s: dir/oe_n got %b/%b expected %b/%b", tag, xcvr_dir, xcvr_oe_n, ed, eo);
        end
    endtask

    // monitor: pops every expectation due on this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.dir, e.oe_n, e.tag);
        end
    end

    task automatic push(input int at, input logic d, input logic o, input string tag);
        exp_t e;
        e.at = at; e.dir = d; e.oe_n = o; e.tag = tag;
        sb.push_back(e);
    endtask

    // kind: 0 ior, 1 iow, 2 memr, 3 memw, 4+n dack channel n
    task automatic set_src(input int kind, input logic v);
        case (kind)
            0: ior_n  = v;
            1: iow_n  = v;
            2: memr_n = v;
            3: memw_n = v;
            default: dack_n[kind-4] = v;
        endcase
    endtask

    task automatic run(input int kind, input logic [23:0] a, input logic [23:0] a_mid,
                       input logic ed, input logic eo, input string tag);
        @(negedge clk);
        addr = a;
        set_src(kind, 1'b0);
        push(cyc + 2, 1'b0, 1'b1, {tag, " R4 not before third edge"});
        push(cyc + 3, ed, eo, tag);
        repeat (4) @(negedge clk);
        addr = a_mid;
        push(cyc + 2, ed, eo, {tag, " R12 held"});
        repeat (2) @(negedge clk);
        set_src(kind, 1'b1);
        push(cyc + 2, ed, eo, {tag, " R4 release not early"});
        push(cyc + 3, 1'b0, 1'b1, {tag, " R4 released"});
        repeat (5) @(negedge clk);
    endtask

    task automatic do_reset(input logic dc);
        @(negedge clk);
        rst = 1'b1;
        dskchg = dc;
        repeat (3) @(negedge clk);
        compare(1'b0, 1'b1, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        compare(1'b0, 1'b1, "R1 after reset");
        dskchg = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, got running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);

        run(0, 24'h0003F2, 24'h0003F2, 1'b1, 1'b0, "R2 R6 ior floppy primary");
        run(0, 24'h000300, 24'h000300, 1'b1, 1'b1, "R2 R7 ior no device");
        run(1, 24'h0003F2, 24'h0003F2, 1'b0, 1'b0, "R5 R6 iow floppy");
        run(2, 24'h0F0000, 24'h0F0000, 1'b1, 1'b0, "R3 memr bios");
        run(2, 24'h0A0000, 24'h0A0000, 1'b0, 1'b1, "R3 memr outside bios");
        run(3, 24'h0E0000, 24'h0E0000, 1'b0, 1'b0, "R5 R6 memw bios");
        run(0, 24'h000060, 24'h000060, 1'b1, 1'b0, "R6 ior keyboard");
        run(1, 24'h000071, 24'h000071, 1'b0, 1'b0, "R6 iow rtc");
        run(1, 24'h000374, 24'h000374, 1'b0, 1'b0, "R6 iow floppy secondary");

        cs_en = 5'b11011;
        run(0, 24'h000064, 24'h000064, 1'b1, 1'b1, "R7 keyboard disabled");
        cs_en = 5'b01111;
        run(2, 24'h0F0000, 24'h0F0000, 1'b0, 1'b1, "R3 R7 bios disabled");
        cs_en = 5'b11111;

        ide_en = 1'b0;
        run(0, 24'h0003F7, 24'h0003F7, 1'b1, 1'b1, "R9 ior 3F7 ide off");
        run(0, 24'h000377, 24'h000377, 1'b1, 1'b1, "R9 ior 377 ide off");
        run(1, 24'h0003F7, 24'h0003F7, 1'b0, 1'b0, "R9 iow 3F7 ide off");
        ide_en = 1'b1;
        run(0, 24'h000377, 24'h000377, 1'b1, 1'b0, "R9 ior 377 ide on");

        run(0, 24'h0003F2, 24'h000300, 1'b1, 1'b0, "R12 address moved mid strobe");
        run(0, 24'h000300, 24'h0003F2, 1'b1, 1'b1, "R12 address moved into device");

        dma_from_util = 1'b1;
        run(6, 24'h000000, 24'h000000, 1'b1, 1'b0, "R10 R11 dack2 read from util");
        run(5, 24'h000000, 24'h000000, 1'b0, 1'b1, "R10 dack1 not utility");
        dma_from_util = 1'b0;
        run(6, 24'h000000, 24'h000000, 1'b0, 1'b0, "R10 R11 dack2 write to util");
        dma_from_util = 1'b1;
        dor_ign_dack2 = 1'b1;
        run(6, 24'h000000, 24'h000000, 1'b1, 1'b1, "R11 dack2 ignored");
        dor_ign_dack2 = 1'b0;
        dma_from_util = 1'b0;

        do_reset(1'b0);
        run(0, 24'h0003F2, 24'h0003F2, 1'b1, 1'b1, "R8 floppy blocked by disk change");
        run(1, 24'h000372, 24'h000372, 1'b0, 1'b1, "R8 floppy secondary blocked");
        run(0, 24'h000060, 24'h000060, 1'b1, 1'b0, "R8 keyboard unaffected");
        do_reset(1'b1);
        run(0, 24'h0003F2, 24'h0003F2, 1'b1, 1'b0, "R8 floppy after clean reset");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule